// File: doc/BRIEF.md
# Divided-Clock Countdown Timer

This block is a 32-bit countdown timer of the kind found beside a local interrupt controller, reached through a small register interface. A bus-clock tick strobe feeds a prescaler. Every N strobes, where N is a power of two from 1 to 128 picked through a 4-bit divide code, the prescaler takes one step off the current count. Software loads a start value by writing the initial-count register. That write copies the value into the current count and starts counting. Writing zero stops the timer.

When the count reaches zero, the block raises a one-cycle interrupt request that carries a programmed 8-bit vector, unless the mask bit is set. In one-shot mode the count then rests at zero. In periodic mode it reloads from the initial count on the next prescaled step. A third mode encoding is accepted and read back, but it holds the counter idle.

Top module: `cdt_timer`

## Requirements
- R1: Register offsets are: control at 0x320, initial count at 0x380, current count (read-only) at 0x390, and divide code at 0x3E0. The control register holds the vector in bits 7:0, the mask in bit 16 and the mode in bits 18:17. Every other control bit reads 0, and the divide register reads back its 4 written bits. After reset, control reads 0x00010000 (masked) and every other register reads 0.
- R2: The divide code is decoded from bits {3,1,0}, and bit 2 is disregarded. The ratios are 0x0=÷2, 0x1=÷4, 0x2=÷8, 0x3=÷16, 0x8=÷32, 0x9=÷64, 0xA=÷128 and 0xB=÷1. The current count drops by one on every N-th tick after the prescaler phase was last cleared.
- R3: A write of a nonzero value to the initial count loads the current count with that value, clears the prescaler phase and starts counting. The initial count reads back the written value.
- R4: A write of zero to the initial count stops the timer. The current count then reads 0 and no interrupt follows.
- R5: In one-shot mode (mode 0), the step that takes the count from 1 to 0 raises irq for exactly one cycle, in the cycle the count first reads 0. The count then stays at 0.
- R6: In periodic mode (mode 1), the count reloads from the initial count on the first prescaled step after it reaches 0, and it raises irq at every expiry.
- R7: With the mask bit set, the count still decrements, but irq is never raised.
- R8: In mode 2 (and the unused mode 3), the counter is idle, the current count reads 0 and irq is never raised.
- R9: A write to the divide register clears the prescaler phase, so the next step comes a full N ticks later.
- R10: Reads of unmapped offsets return 0. Writes to the current-count offset have no effect.
- R11: irq_vec carries the control vector while irq is high and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | Bus-clock strobe feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when rd_en is low |
| irq | output | 1 | One-cycle expiry pulse |
| irq_vec | output | 8 | Vector sent with irq |

## Verification
Read data is combinational. The bench therefore samples rdata in the same cycle as the read strobe, half a clock after driving it. That sample reflects every tick and write of earlier cycles. The count update from a tick lands on the edge that closes the tick cycle, and irq is registered beside it. The bench therefore expects each interrupt in the cycle right after the expiring tick and queues the expected vector before it issues the ticks. During every write and read cycle the bench holds bus_tick low, so the tick counts that produce each expected value stay exact.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   typedef enum logic [1:0] {
      TM_ONESHOT  = 2'd0,
      TM_PERIODIC = 2'd1,
      TM_DEADLINE = 2'd2,
      TM_RSVD     = 2'd3
   } tmode_e;

   // log2 of the largest divide ratio (128)
   localparam int MAX_SHIFT = 7;
   localparam int SHIFT_W   = 3;

   // Divide code to shift amount: bits {3,1,0} form a 3-bit selector,
   // selector 7 means divide-by-1, otherwise shift = selector + 1.
   function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] code);
      logic [2:0] sel;
      sel = {code[3], code[1:0]};
      return (sel == 3'd7) ? 3'd0 : sel + 3'd1;
   endfunction

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
   import cdt_pkg::*;
#(
   parameter int PRE_W = MAX_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               step
);

   logic [PRE_W-1:0] phase_q;
   logic [PRE_W-1:0] sel_mask;

   generate
      if (PRE_W < MAX_SHIFT) begin : g_bad_width
         $error("cdt_prescale: PRE_W must cover the largest divide ratio");
      end
      for (genvar i = 0; i < PRE_W; i++) begin : g_mask
         assign sel_mask[i] = (i < int'(shift));
      end
   endgenerate

   // a step fires on the tick whose phase has all selected low bits set
   assign step = tick && !restart && (&(phase_q | ~sel_mask));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart) begin
         phase_q <= '0;
      end else if (tick) begin
         phase_q <= phase_q + 1'b1;
      end
   end

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
   import cdt_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter int                DATA_W   = 32,
   parameter int                VEC_W    = 8,
   parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h320,
   parameter logic [ADDR_W-1:0] OFS_INIT = 12'h380,
   parameter logic [ADDR_W-1:0] OFS_CUR  = 12'h390,
   parameter logic [ADDR_W-1:0] OFS_DIV  = 12'h3E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cur_view,
   output logic [DATA_W-1:0] rdata,
   output logic [VEC_W-1:0]  vec_q,
   output logic              mask_q,
   output tmode_e            mode_q,
   output logic [DATA_W-1:0] init_q,
   output logic [3:0]        div_q,
   output logic              init_wr,
   output logic              div_wr
);

   localparam int MASK_BIT = 16;
   localparam int MODE_LO  = 17;

   generate
      if (VEC_W < 1 || VEC_W > MASK_BIT) begin : g_bad_vec
         $error("cdt_regs: VEC_W must lie in 1..16");
      end
      if (DATA_W < MODE_LO + 2) begin : g_bad_data
         $error("cdt_regs: DATA_W too narrow for control fields");
      end
   endgenerate

   logic ctrl_wr;
   logic [DATA_W-1:0] ctrl_view;

   assign ctrl_wr = wr_en && (addr == OFS_CTRL);
   assign init_wr = wr_en && (addr == OFS_INIT);
   assign div_wr  = wr_en && (addr == OFS_DIV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q  <= '0;
         mask_q <= 1'b1;
         mode_q <= TM_ONESHOT;
         init_q <= '0;
         div_q  <= '0;
      end else begin
         if (ctrl_wr) begin
            vec_q  <= wdata[VEC_W-1:0];
            mask_q <= wdata[MASK_BIT];
            mode_q <= tmode_e'(wdata[MODE_LO+1:MODE_LO]);
         end
         if (init_wr) init_q <= wdata;
         if (div_wr)  div_q  <= wdata[3:0];
      end
   end

   always_comb begin
      ctrl_view                      = '0;
      ctrl_view[VEC_W-1:0]           = vec_q;
      ctrl_view[MASK_BIT]            = mask_q;
      ctrl_view[MODE_LO+1:MODE_LO]   = mode_q;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr == OFS_CTRL)      rdata = ctrl_view;
         else if (addr == OFS_INIT) rdata = init_q;
         else if (addr == OFS_CUR)  rdata = cur_view;
         else if (addr == OFS_DIV)  rdata = {{(DATA_W-4){1'b0}}, div_q};
      end
   end

endmodule

// File: rtl/cdt_count.sv
module cdt_count
   import cdt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic [DATA_W-1:0] reload_val,
   input  tmode_e            mode,
   input  logic              mask,
   input  logic [VEC_W-1:0]  vec,
   output logic [DATA_W-1:0] cur_q,
   output logic [DATA_W-1:0] cur_view,
   output logic              irq,
   output logic [VEC_W-1:0]  irq_vec
);

   logic run_q;
   logic idle;

   generate
      if (DATA_W < 2) begin : g_bad_cnt
         $error("cdt_count: DATA_W must be at least 2");
      end
   endgenerate

   assign idle     = mode[1];
   assign cur_view = idle ? '0 : cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= '0;
         run_q   <= 1'b0;
         irq     <= 1'b0;
         irq_vec <= '0;
      end else begin
         irq     <= 1'b0;
         irq_vec <= '0;
         if (load) begin
            cur_q <= idle ? '0 : load_val;
            run_q <= !idle && (load_val != '0);
         end else if (step && run_q && !idle) begin
            if (cur_q == DATA_W'(1)) begin
               cur_q <= '0;
               if (mode != TM_PERIODIC) run_q <= 1'b0;
               if (!mask) begin
                  irq     <= 1'b1;
                  irq_vec <= vec;
               end
            end else if (cur_q == '0) begin
               if (mode == TM_PERIODIC) cur_q <= reload_val;
               else                     run_q <= 1'b0;
            end else begin
               cur_q <= cur_q - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
   import cdt_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter int                DATA_W   = 32,
   parameter int                VEC_W    = 8,
   parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h320,
   parameter logic [ADDR_W-1:0] OFS_INIT = 12'h380,
   parameter logic [ADDR_W-1:0] OFS_CUR  = 12'h390,
   parameter logic [ADDR_W-1:0] OFS_DIV  = 12'h3E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic [VEC_W-1:0]  irq_vec
);

   logic [VEC_W-1:0]  vec_q;
   logic              mask_q;
   tmode_e            mode_q;
   logic [DATA_W-1:0] init_q;
   logic [3:0]        div_q;
   logic              init_wr;
   logic              div_wr;
   logic [DATA_W-1:0] cur_q;
   logic [DATA_W-1:0] cur_view;
   logic              step;

   cdt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
      .OFS_CTRL(OFS_CTRL), .OFS_INIT(OFS_INIT),
      .OFS_CUR(OFS_CUR), .OFS_DIV(OFS_DIV)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .cur_view(cur_view), .rdata(rdata),
      .vec_q(vec_q), .mask_q(mask_q), .mode_q(mode_q), .init_q(init_q),
      .div_q(div_q), .init_wr(init_wr), .div_wr(div_wr)
   );

   cdt_prescale #(.PRE_W(MAX_SHIFT)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(bus_tick),
      .restart(init_wr | div_wr), .shift(div_shift(div_q)), .step(step)
   );

   cdt_count #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .load(init_wr),
      .load_val(wdata), .reload_val(init_q), .mode(mode_q),
      .mask(mask_q), .vec(vec_q), .cur_q(cur_q), .cur_view(cur_view),
      .irq(irq), .irq_vec(irq_vec)
   );

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
   parameter int                ADDR_W   = 12,
   parameter int                DATA_W   = 32,
   parameter int                VEC_W    = 8,
   parameter logic [ADDR_W-1:0] OFS_INIT = 12'h380
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              irq,
   input logic [VEC_W-1:0]  irq_vec,
   input logic [DATA_W-1:0] cur_q,
   input logic              mask_q,
   input logic [1:0]        mode_q
);

   logic init_w;
   assign init_w = wr_en && (addr == OFS_INIT);

   p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cur_q == '0));

   p_oneshot_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0 && cur_q == '0 && !init_w) |=> (cur_q == '0));

   p_zero_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (init_w && wdata == '0) |=> (cur_q == '0));

   p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !$past(mask_q));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && !init_w) |=> $stable(cur_q));

   p_vec_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (irq_vec == '0));

endmodule

bind cdt_timer cdt_timer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .OFS_INIT(OFS_INIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .irq(irq), .irq_vec(irq_vec), .cur_q(cur_q), .mask_q(mask_q),
   .mode_q(mode_q)
);

// File: tb/cdt_timer_test.sv
`timescale 1ns/1ps
module cdt_timer_test;

   localparam logic [11:0] A_CTRL = 12'h320;
   localparam logic [11:0] A_INIT = 12'h380;
   localparam logic [11:0] A_CUR  = 12'h390;
   localparam logic [11:0] A_DIV  = 12'h3E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [7:0]  irq_vec;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t rd_q[$];
   item_t irq_q[$];

   always #2 clk = ~clk;

   cdt_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq(irq), .irq_vec(irq_vec)
   );

   // monitor: compares results as they appear
   always @(negedge clk) begin
      if (rst_n && rd_en) begin
         item_t it;
         n_chk++;
         if (rd_q.size() == 0) begin
            n_fail++;
            $display("FAIL unplanned read: actual %h expected none", rdata);
         end else begin
            it = rd_q.pop_front();
            if (rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
            end
         end
      end
      if (rst_n && irq === 1'b1) begin
         item_t it;
         n_chk++;
         if (irq_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7/R8/R4 unexpected irq: actual vec %h expected no irq", irq_vec);
         end else begin
            it = irq_q.pop_front();
            if (irq_vec !== it.exp[7:0]) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, irq_vec, it.exp[7:0]);
            end
         end
      end
   end

   task automatic drive(input bit w, input bit r, input logic [11:0] a,
                        input logic [31:0] d, input bit t);
      @(posedge clk); #1;
      wr_en = w; rd_en = r; addr = a; wdata = d; bus_tick = t;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      drive(1, 0, a, d, 0);
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      rd_q.push_back('{exp: e, tag: tag});
      drive(0, 1, a, '0, 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, '0, '0, 1);
   endtask

   task automatic exp_irq(input logic [7:0] v, input string tag);
      irq_q.push_back('{exp: {24'h0, v}, tag: tag});
   endtask

   task automatic div_case(input logic [3:0] code, input int n,
                           input logic [31:0] e, input string tag);
      wr(A_DIV, {28'h0, code});
      wr(A_INIT, 32'd10);
      ticks(n);
      rd(A_CUR, e, tag);
   endtask

   task automatic finish_run();
      if (done) return;
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, 32'h0001_0000, "R1 ctrl reset");
      rd(A_INIT, 32'h0, "R1 init reset");
      rd(A_CUR,  32'h0, "R1 cur reset");
      rd(A_DIV,  32'h0, "R1 div reset");

      // R5 one-shot at divide-by-1, R3 load
      wr(A_DIV, 32'hB);
      wr(A_CTRL, 32'h40);
      wr(A_INIT, 32'd5);
      ticks(4);
      rd(A_CUR, 32'd1, "R3 load then count");
      exp_irq(8'h40, "R5 one-shot irq vector");
      ticks(1);
      rd(A_CUR, 32'd0, "R5 expiry count");
      ticks(3);
      rd(A_CUR, 32'd0, "R5 rests at zero");
      rd(A_INIT, 32'd5, "R3 init readback");
      rd(A_CTRL, 32'h40, "R1 ctrl readback");

      // R2 divide-by-2
      wr(A_DIV, 32'h0);
      wr(A_INIT, 32'd3);
      ticks(5);
      rd(A_CUR, 32'd1, "R2 div2");
      exp_irq(8'h40, "R2 div2 expiry");
      ticks(1);
      rd(A_CUR, 32'd0, "R2 div2 zero");

      // R2 remaining ratios
      div_case(4'h1, 8,   32'd8, "R2 div4");
      div_case(4'h2, 8,   32'd9, "R2 div8");
      div_case(4'h3, 32,  32'd8, "R2 div16");
      div_case(4'h8, 64,  32'd8, "R2 div32");
      div_case(4'h9, 64,  32'd9, "R2 div64");
      div_case(4'hA, 127, 32'd10, "R2 div128 before step");
      ticks(1);
      rd(A_CUR, 32'd9, "R2 div128 step");
      div_case(4'h4, 4,   32'd8, "R2 bit2 ignored");
      rd(A_DIV, 32'h4, "R1 div readback");

      // R6 periodic
      wr(A_DIV, 32'hB);
      wr(A_CTRL, 32'h0002_0021);
      wr(A_INIT, 32'd3);
      exp_irq(8'h21, "R6 first period");
      exp_irq(8'h21, "R6 second period");
      ticks(7);
      rd(A_CUR, 32'd0, "R6 zero after two periods");
      ticks(1);
      rd(A_CUR, 32'd3, "R6 reload");
      rd(A_CTRL, 32'h0002_0021, "R1 periodic readback");
      wr(A_INIT, 32'd0);

      // R7 mask
      wr(A_CTRL, 32'h0001_0055);
      wr(A_INIT, 32'd2);
      ticks(1);
      rd(A_CUR, 32'd1, "R7 counts while masked");
      ticks(3);
      rd(A_CUR, 32'd0, "R7 masked expiry");

      // R4 zero stops
      wr(A_CTRL, 32'h40);
      wr(A_INIT, 32'd100);
      ticks(3);
      rd(A_CUR, 32'd97, "R4 running");
      wr(A_INIT, 32'd0);
      rd(A_CUR, 32'd0, "R4 stopped");
      rd(A_INIT, 32'd0, "R4 init zero");
      ticks(5);
      rd(A_CUR, 32'd0, "R4 stays stopped");

      // R8 idle mode
      wr(A_CTRL, 32'h0004_0040);
      wr(A_INIT, 32'd50);
      ticks(10);
      rd(A_CUR, 32'd0, "R8 idle reads zero");
      rd(A_CTRL, 32'h0004_0040, "R8 mode readback");
      rd(A_INIT, 32'd50, "R8 init kept");
      wr(A_CTRL, 32'h40);

      // R9 divide write restarts phase
      wr(A_DIV, 32'h1);
      wr(A_INIT, 32'd20);
      ticks(3);
      wr(A_DIV, 32'h1);
      ticks(3);
      rd(A_CUR, 32'd20, "R9 phase cleared");
      ticks(1);
      rd(A_CUR, 32'd19, "R9 full period");

      // R10 unmapped and read-only
      wr(A_INIT, 32'h30);
      wr(A_CUR, 32'h1234);
      rd(A_CUR, 32'h30, "R10 current count read-only");
      rd(12'h300, 32'h0, "R10 unmapped 0x300");
      rd(12'h3F0, 32'h0, "R10 unmapped 0x3F0");
      rd(12'h321, 32'h0, "R10 unmapped 0x321");

      // R3 large count does not expire
      wr(A_DIV, 32'hB);
      wr(A_INIT, 32'hFFFF_FFFF);
      ticks(100);
      rd(A_CUR, 32'hFFFF_FF9B, "R3 all-ones count");
      wr(A_INIT, 32'd0);

      drive(0, 0, '0, '0, 0);
      repeat (4) @(posedge clk);
      // R11 every expected irq must have appeared
      while (irq_q.size() > 0) begin
         item_t it;
         it = irq_q.pop_front();
         n_chk++;
         n_fail++;
         $display("FAIL %s (R11): actual no irq expected %h", it.tag, it.exp[7:0]);
      end
      finish_run();
   end

endmodule